// File: doc/BRIEF.md
# SECDED Two-Port RAM

A 512-word memory of 33-bit data words with one write side and one read side, each clocked by its own rising edge. Every word written is extended with a single-error-correct, double-error-detect code: six Hamming check bits plus one overall parity bit, so each stored codeword is 40 bits wide. On a read the codeword is checked, a single flipped bit is repaired before the data leaves the block, and two status flags report what was found.

Both the incoming and outgoing words are spread over a pair of 20-bit buses. The low 17 data bits travel on the "lo" bus and the high 16 on the "hi" bus. The unused upper bits of the outputs are held at zero. A static select adds one register stage after the decoder, which trades one cycle of read latency for a shorter path from the array to the outputs. A test-only input XORs a mask into a stored codeword, so that single and double faults can be planted and then observed through a normal read.

Top module: `ecc2p_ram`

## Requirements
- R1: A write happens on a rising `wr_clk` edge when `wr_en` is 2'b11 and `wr_blk` is 3'b111. A later read of the same word address returns the 33-bit word that was written.
- R2: Only address bits [13:5] select the word, on both sides. Bits [4:0] of `wr_addr` and `rd_addr` have no effect.
- R3: A stored word takes data bits [16:0] from `wr_data_lo[16:0]` and bits [32:17] from `wr_data_hi[15:0]`. Input bits `wr_data_lo[19:17]` and `wr_data_hi[19:16]` are ignored. A `wr_en` of 2'b01 or 2'b10 writes nothing.
- R4: Read data bits [16:0] appear on `rd_data_lo[16:0]` and bits [32:17] on `rd_data_hi[15:0]`. `rd_data_lo[19:17]` and `rd_data_hi[19:16]` are always zero.
- R5: The flags {`err_multi`,`err_corr`} read 2'b00 when no error is found and 2'b01 when one bit was corrected, in which case the data are the written word. They read 2'b11 when two bits are in error. 2'b10 never occurs.
- R6: With `dec_pipe`=0, data and flags for a read whose address is sampled at rising `rd_clk` edge k are valid after edge k. With `dec_pipe`=1 they are valid only after edge k+1, and after edge k the outputs still show the previous value.
- R7: A read happens only when `rd_en` is 1 and `rd_blk` is 3'b111. In a cycle that carries no read, the data outputs and both flags are zero, at the latency given in R6. While `rd_rst_n` is low they are zero as well.
- R8: When `wr_blk` is not 3'b111, no write takes place and the addressed word keeps its old contents.
- R9: When a read and a write hit the same word in the same cycle, the read data are undefined. The write still stores the new word, and a later read returns it.
- R10: When `inj_en` is 1 on a `wr_clk` edge that carries no write, `inj_mask` is XORed into the 40-bit codeword at the word selected by `wr_addr`. Codeword bit 39 is the overall parity bit. Bits [38:0] hold Hamming positions 1 to 39, with bit i at position i+1. The check bits sit at positions 1, 2, 4, 8, 16 and 32, and the data bits fill the remaining positions in rising order.
- R11: A single flip of codeword bit 39, the overall parity bit, is reported as a corrected error (2'b01), and the data are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock, rising edge |
| wr_addr | input | 14 | Write address; bits [13:5] select the word |
| wr_data_hi | input | 20 | Write data bits [32:17] on [15:0] |
| wr_data_lo | input | 20 | Write data bits [16:0] on [16:0] |
| wr_en | input | 2 | Write enables; both bits must be set |
| wr_blk | input | 3 | Write block select; all ones to enable |
| inj_en | input | 1 | Test: XOR `inj_mask` into the stored codeword |
| inj_mask | input | 40 | Test: codeword flip mask |
| rd_clk | input | 1 | Read-side clock, rising edge |
| rd_rst_n | input | 1 | Asynchronous reset of the read output registers, active low |
| rd_addr | input | 14 | Read address; bits [13:5] select the word |
| rd_en | input | 1 | Read enable |
| rd_blk | input | 3 | Read block select; all ones to enable |
| dec_pipe | input | 1 | Static: 1 adds a register after the decoder |
| rd_data_hi | output | 20 | Read data bits [32:17] on [15:0] |
| rd_data_lo | output | 20 | Read data bits [16:0] on [16:0] |
| err_corr | output | 1 | Error seen: corrected, or part of an uncorrectable error |
| err_multi | output | 1 | Uncorrectable multi-bit error |

## Verification
Data patterns of all zeros, all ones, alternating bits and a walking mix are written with junk on the unused input bits. Reading them back separates correct bus packing from swapped or shifted halves. Single-bit masks are planted in a check position, in data positions and in the overall parity bit, which shows that the syndrome repairs the right bit. A two-bit mask must give the uncorrectable code. Reads through a gated block select, through a low read enable and through the extra decode stage show when outputs are forced to zero. They also show the exact cycle at which data appear, which tells a missing pipeline stage from an extra one.

// File: rtl/ecc2p_pkg.sv
package ecc2p_pkg;

   // Default geometry of the protected word and its buses
   localparam int DEF_DATA_W = 33;
   localparam int DEF_LO_W   = 17;
   localparam int DEF_BUS_W  = 20;
   localparam int DEF_DEPTH  = 512;
   localparam int DEF_ADDR_W = 14;
   localparam int DEF_BLK_W  = 3;

   // Smallest count of Hamming check bits that covers dw data bits
   function automatic int hamming_chk_bits(input int dw);
      int r;
      r = 1;
      while ((1 << r) < dw + r + 1) r++;
      return r;
   endfunction

   // True when a Hamming position is reserved for a check bit
   function automatic bit is_chk_pos(input int p);
      return (p & (p - 1)) == 0;
   endfunction

endpackage

// File: rtl/ecc2p_encoder.sv
module ecc2p_encoder #(
   parameter int DATA_W = 33,
   parameter int CHK_W  = 6,
   localparam int HAM_W = DATA_W + CHK_W,
   localparam int CW_W  = HAM_W + 1
) (
   input  logic [DATA_W-1:0] data_i,
   output logic [CW_W-1:0]   code_o
);
   import ecc2p_pkg::*;

   logic [HAM_W:1] pos;

   always_comb begin
      int d;
      d = 0;
      pos = '0;
      // scatter data over the non-check positions
      for (int p = 1; p <= HAM_W; p++) begin
         if (!is_chk_pos(p)) begin
            pos[p] = data_i[d];
            d++;
         end
      end
      // each check bit covers the positions that have its weight set
      for (int k = 0; k < CHK_W; k++) begin
         logic par;
         par = 1'b0;
         for (int p = 1; p <= HAM_W; p++) begin
            if (((p >> k) & 1) == 1 && !is_chk_pos(p)) par = par ^ pos[p];
         end
         pos[1 << k] = par;
      end
   end

   assign code_o = {^pos, pos};

endmodule

// File: rtl/ecc2p_decoder.sv
module ecc2p_decoder #(
   parameter int DATA_W = 33,
   parameter int CHK_W  = 6,
   localparam int HAM_W = DATA_W + CHK_W,
   localparam int CW_W  = HAM_W + 1
) (
   input  logic [CW_W-1:0]   code_i,
   output logic [DATA_W-1:0] data_o,
   output logic              corr_o,
   output logic              multi_o
);
   import ecc2p_pkg::*;

   logic [HAM_W:1]   pos_raw;
   logic [HAM_W:1]   pos_fix;
   logic [CHK_W-1:0] syn;
   logic             par_err;

   assign pos_raw = code_i[HAM_W-1:0];
   assign par_err = ^code_i;

   // syndrome: XOR of the position numbers of all set bits
   always_comb begin
      syn = '0;
      for (int p = 1; p <= HAM_W; p++) begin
         if (pos_raw[p]) syn = syn ^ CHK_W'(p);
      end
   end

   // repair the named position only when overall parity says odd
   always_comb begin
      pos_fix = pos_raw;
      for (int p = 1; p <= HAM_W; p++) begin
         if (par_err && syn == CHK_W'(p)) pos_fix[p] = ~pos_raw[p];
      end
   end

   always_comb begin
      int d;
      d = 0;
      data_o = '0;
      for (int p = 1; p <= HAM_W; p++) begin
         if (!is_chk_pos(p)) begin
            data_o[d] = pos_fix[p];
            d++;
         end
      end
   end

   // odd parity with a syndrome beyond the word cannot be a single flip
   always_comb begin
      if (par_err) begin
         corr_o  = 1'b1;
         multi_o = (32'(syn) > HAM_W);
      end else if (syn != '0) begin
         corr_o  = 1'b1;
         multi_o = 1'b1;
      end else begin
         corr_o  = 1'b0;
         multi_o = 1'b0;
      end
   end

endmodule

// File: rtl/ecc2p_array.sv
module ecc2p_array #(
   parameter int DEPTH  = 512,
   parameter int WORD_W = 40,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              wclk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic              flip_en,
   input  logic [WORD_W-1:0] flip_mask,
   input  logic              rclk,
   input  logic              re,
   input  logic [AW-1:0]     raddr,
   output logic [WORD_W-1:0] rdata
);

   logic [WORD_W-1:0] store [DEPTH];

   always_ff @(posedge wclk) begin
      if (we)           store[waddr] <= wdata;
      else if (flip_en) store[waddr] <= store[waddr] ^ flip_mask;
   end

   always_ff @(posedge rclk) begin
      if (re) rdata <= store[raddr];
   end

endmodule

// File: rtl/ecc2p_ram.sv
module ecc2p_ram #(
   parameter int DATA_W  = ecc2p_pkg::DEF_DATA_W,
   parameter int LO_W    = ecc2p_pkg::DEF_LO_W,
   parameter int BUS_W   = ecc2p_pkg::DEF_BUS_W,
   parameter int DEPTH   = ecc2p_pkg::DEF_DEPTH,
   parameter int ADDR_W  = ecc2p_pkg::DEF_ADDR_W,
   parameter int BLK_W   = ecc2p_pkg::DEF_BLK_W,
   localparam int HI_W   = DATA_W - LO_W,
   localparam int CHK_W  = ecc2p_pkg::hamming_chk_bits(DATA_W),
   localparam int CW_W   = DATA_W + CHK_W + 1,
   localparam int WA_W   = $clog2(DEPTH),
   localparam int ADDR_LSB = ADDR_W - WA_W
) (
   input  logic              wr_clk,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BUS_W-1:0]  wr_data_hi,
   input  logic [BUS_W-1:0]  wr_data_lo,
   input  logic [1:0]        wr_en,
   input  logic [BLK_W-1:0]  wr_blk,
   input  logic              inj_en,
   input  logic [CW_W-1:0]   inj_mask,
   input  logic              rd_clk,
   input  logic              rd_rst_n,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_en,
   input  logic [BLK_W-1:0]  rd_blk,
   input  logic              dec_pipe,
   output logic [BUS_W-1:0]  rd_data_hi,
   output logic [BUS_W-1:0]  rd_data_lo,
   output logic              err_corr,
   output logic              err_multi
);

   // elaboration checks on the geometry
   if (LO_W > BUS_W || HI_W > BUS_W || HI_W < 1) begin : g_bad_split
      $error("data word does not fit the two buses");
   end
   if (ADDR_LSB < 0) begin : g_bad_addr
      $error("address bus too narrow for depth");
   end
   if ((1 << WA_W) != DEPTH) begin : g_bad_depth
      $error("depth must be a power of two");
   end

   // ---------------- write side ----------------
   logic              wr_go;
   logic [DATA_W-1:0] wr_word;
   logic [CW_W-1:0]   wr_code;
   logic [WA_W-1:0]   wr_wa;

   assign wr_go   = (&wr_en) && (&wr_blk);
   assign wr_word = {wr_data_hi[HI_W-1:0], wr_data_lo[LO_W-1:0]};
   assign wr_wa   = wr_addr[ADDR_W-1:ADDR_LSB];

   ecc2p_encoder #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc (
      .data_i (wr_word),
      .code_o (wr_code)
   );

   // ---------------- storage ----------------
   logic            rd_go;
   logic [WA_W-1:0] rd_wa;
   logic [CW_W-1:0] rd_code;

   assign rd_go = rd_en && (&rd_blk);
   assign rd_wa = rd_addr[ADDR_W-1:ADDR_LSB];

   ecc2p_array #(.DEPTH(DEPTH), .WORD_W(CW_W)) u_arr (
      .wclk      (wr_clk),
      .we        (wr_go),
      .waddr     (wr_wa),
      .wdata     (wr_code),
      .flip_en   (inj_en),
      .flip_mask (inj_mask),
      .rclk      (rd_clk),
      .re        (rd_go),
      .raddr     (rd_wa),
      .rdata     (rd_code)
   );

   // ---------------- read side ----------------
   logic              rd_vld_q;
   logic [DATA_W-1:0] dec_data;
   logic              dec_corr;
   logic              dec_multi;
   logic [DATA_W-1:0] s1_data;
   logic              s1_corr;
   logic              s1_multi;
   logic [DATA_W-1:0] out_data;
   logic              out_corr;
   logic              out_multi;

   always_ff @(posedge rd_clk or negedge rd_rst_n) begin
      if (!rd_rst_n) rd_vld_q <= 1'b0;
      else           rd_vld_q <= rd_go;
   end

   ecc2p_decoder #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_dec (
      .code_i  (rd_code),
      .data_o  (dec_data),
      .corr_o  (dec_corr),
      .multi_o (dec_multi)
   );

   // data and flags are zero for any cycle that carried no read
   assign s1_data  = rd_vld_q ? dec_data : '0;
   assign s1_corr  = rd_vld_q && dec_corr;
   assign s1_multi = rd_vld_q && dec_multi;

   logic [DATA_W-1:0] p_data;
   logic              p_corr;
   logic              p_multi;

   always_ff @(posedge rd_clk or negedge rd_rst_n) begin
      if (!rd_rst_n) begin
         p_data  <= '0;
         p_corr  <= 1'b0;
         p_multi <= 1'b0;
      end else begin
         p_data  <= s1_data;
         p_corr  <= s1_corr;
         p_multi <= s1_multi;
      end
   end

   assign out_data  = dec_pipe ? p_data  : s1_data;
   assign out_corr  = dec_pipe ? p_corr  : s1_corr;
   assign out_multi = dec_pipe ? p_multi : s1_multi;

   // ---------------- bus packing ----------------
   if (LO_W < BUS_W) begin : g_lo_pad
      assign rd_data_lo = {{(BUS_W-LO_W){1'b0}}, out_data[LO_W-1:0]};
   end else begin : g_lo_full
      assign rd_data_lo = out_data[LO_W-1:0];
   end

   if (HI_W < BUS_W) begin : g_hi_pad
      assign rd_data_hi = {{(BUS_W-HI_W){1'b0}}, out_data[DATA_W-1:LO_W]};
   end else begin : g_hi_full
      assign rd_data_hi = out_data[DATA_W-1:LO_W];
   end

   assign err_corr  = out_corr;
   assign err_multi = out_multi;

   // input bits that carry no meaning
   logic unused_bits;
   if (ADDR_LSB > 0 && LO_W < BUS_W && HI_W < BUS_W) begin : g_unused
      assign unused_bits = ^{wr_addr[ADDR_LSB-1:0], rd_addr[ADDR_LSB-1:0],
                             wr_data_lo[BUS_W-1:LO_W], wr_data_hi[BUS_W-1:HI_W]};
   end else begin : g_no_unused
      assign unused_bits = 1'b0;
   end

endmodule

// File: rtl/ecc2p_ram_chk.sv
module ecc2p_ram_chk #(
   parameter int BUS_W = 20,
   parameter int LO_W  = 17,
   parameter int HI_W  = 16,
   parameter int BLK_W = 3
) (
   input logic             rd_clk,
   input logic             rd_rst_n,
   input logic             rd_en,
   input logic [BLK_W-1:0] rd_blk,
   input logic             dec_pipe,
   input logic [BUS_W-1:0] rd_data_hi,
   input logic [BUS_W-1:0] rd_data_lo,
   input logic             err_corr,
   input logic             err_multi
);

   logic no_rd;
   logic out_zero;

   assign no_rd    = !(rd_en && (&rd_blk));
   assign out_zero = (rd_data_hi == '0) && (rd_data_lo == '0) && !err_corr && !err_multi;

   AST_UPPER_ZERO: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      (rd_data_lo >> LO_W) == '0 && (rd_data_hi >> HI_W) == '0); // R4

   AST_FLAG_CODE: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      !(err_multi && !err_corr)); // R5

   AST_NOREAD_DIRECT: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      (!dec_pipe && no_rd) |=> (dec_pipe || out_zero)); // R7

   AST_NOREAD_PIPED: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      (dec_pipe && no_rd) |=> ##1 (!dec_pipe || out_zero)); // R6

endmodule

bind ecc2p_ram ecc2p_ram_chk #(
   .BUS_W (BUS_W),
   .LO_W  (LO_W),
   .HI_W  (HI_W),
   .BLK_W (BLK_W)
) u_chk (
   .rd_clk     (rd_clk),
   .rd_rst_n   (rd_rst_n),
   .rd_en      (rd_en),
   .rd_blk     (rd_blk),
   .dec_pipe   (dec_pipe),
   .rd_data_hi (rd_data_hi),
   .rd_data_lo (rd_data_lo),
   .err_corr   (err_corr),
   .err_multi  (err_multi)
);

// File: tb/test_ecc2p_ram.sv
module test_ecc2p_ram;

   localparam int CLK_P = 10;

   logic        clk;
   logic [13:0] wr_addr;
   logic [19:0] wr_data_hi, wr_data_lo;
   logic [1:0]  wr_en;
   logic [2:0]  wr_blk;
   logic        inj_en;
   logic [39:0] inj_mask;
   logic        rd_rst_n;
   logic [13:0] rd_addr;
   logic        rd_en;
   logic [2:0]  rd_blk;
   logic        dec_pipe;
   logic [19:0] rd_data_hi, rd_data_lo;
   logic        err_corr, err_multi;

   int checks = 0;
   int errors = 0;

   ecc2p_ram i_ecc2p_ram (
      .wr_clk(clk), .wr_addr(wr_addr), .wr_data_hi(wr_data_hi), .wr_data_lo(wr_data_lo),
      .wr_en(wr_en), .wr_blk(wr_blk), .inj_en(inj_en), .inj_mask(inj_mask),
      .rd_clk(clk), .rd_rst_n(rd_rst_n), .rd_addr(rd_addr), .rd_en(rd_en),
      .rd_blk(rd_blk), .dec_pipe(dec_pipe), .rd_data_hi(rd_data_hi),
      .rd_data_lo(rd_data_lo), .err_corr(err_corr), .err_multi(err_multi)
   );

   initial clk = 1'b0;
   always #(CLK_P/2) clk = ~clk;

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [32:0] out_word();
      return {rd_data_hi[15:0], rd_data_lo[16:0]};
   endfunction

   function automatic logic [13:0] wa(input int w);
      return {9'(w), 5'b0};
   endfunction

   task automatic wr(input logic [13:0] a, input logic [32:0] d,
                     input logic [1:0] en = 2'b11, input logic [2:0] blk = 3'b111);
      @(negedge clk);
      wr_addr    = a;
      wr_data_lo = {3'b101, d[16:0]};
      wr_data_hi = {4'b1011, d[32:17]};
      wr_en      = en;
      wr_blk     = blk;
      @(negedge clk);
      wr_en      = 2'b00;
      wr_blk     = 3'b000;
   endtask

   task automatic inject(input logic [13:0] a, input logic [39:0] m);
      @(negedge clk);
      wr_addr  = a;
      inj_mask = m;
      inj_en   = 1'b1;
      @(negedge clk);
      inj_en   = 1'b0;
   endtask

   // read, wait for the selected latency, then sample at a falling edge
   task automatic rd(input logic [13:0] a, input logic [2:0] blk = 3'b111, input logic en = 1'b1);
      @(negedge clk);
      rd_addr = a;
      rd_en   = en;
      rd_blk  = blk;
      @(negedge clk);
      rd_en   = 1'b0;
      rd_blk  = 3'b000;
      if (dec_pipe) @(negedge clk);
   endtask

   task automatic rd_expect(input string req, input logic [13:0] a, input logic [32:0] d,
                            input logic [1:0] flags);
      rd(a);
      check(req, 64'(out_word()), 64'(d));
      check(req, 64'({err_multi, err_corr}), 64'(flags));
   endtask

   task automatic t_reset();
      check("R7 reset data", 64'({rd_data_hi, rd_data_lo}), 64'd0);
      check("R7 reset flags", 64'({err_multi, err_corr}), 64'd0);
   endtask

   task automatic t_basic();
      logic [32:0] pat [4];
      pat[0] = 33'h0_0000_0000;
      pat[1] = 33'h1_FFFF_FFFF;
      pat[2] = 33'h0_AAAA_5555;
      pat[3] = 33'h1_2345_6789;
      for (int i = 0; i < 4; i++) wr(wa(10 + i), pat[i]);
      for (int i = 0; i < 4; i++) begin
         rd_expect("R1 R3 readback", wa(10 + i), pat[i], 2'b00);
         check("R4 upper bits zero", 64'({rd_data_hi[19:16], rd_data_lo[19:17]}), 64'd0);
      end
      wr(wa(511), 33'h1_0001_8000);
      rd_expect("R1 last word", wa(511), 33'h1_0001_8000, 2'b00);
   endtask

   task automatic t_addr_lsbs();
      wr({9'd5, 5'b10101}, 33'h0_1357_9BDF);
      rd_expect("R2 low address bits", {9'd5, 5'b01010}, 33'h0_1357_9BDF, 2'b00);
   endtask

   task automatic t_partial_we();
      wr(wa(20), 33'h0_0F0F_0F0F);
      wr(wa(20), 33'h1_F0F0_F0F0, 2'b01);
      wr(wa(20), 33'h1_F0F0_F0F0, 2'b10);
      rd_expect("R3 partial write enable", wa(20), 33'h0_0F0F_0F0F, 2'b00);
   endtask

   task automatic t_blk_write();
      wr(wa(21), 33'h0_1111_2222);
      wr(wa(21), 33'h1_3333_4444, 2'b11, 3'b101);
      rd_expect("R8 write block gated", wa(21), 33'h0_1111_2222, 2'b00);
   endtask

   task automatic t_blk_read();
      rd_expect("R7 before gating", wa(21), 33'h0_1111_2222, 2'b00);
      rd(wa(21), 3'b110, 1'b1);
      check("R7 read block gated", 64'({rd_data_hi, rd_data_lo}), 64'd0);
      rd(wa(21), 3'b111, 1'b1);
      rd(wa(21), 3'b111, 1'b0);
      check("R7 read enable low", 64'({rd_data_hi, rd_data_lo, err_multi, err_corr}), 64'd0);
   endtask

   task automatic t_collide();
      wr(wa(30), 33'h0_0000_00FF);
      @(negedge clk);
      wr_addr = wa(30); wr_data_lo = 20'h0_BEEF; wr_data_hi = 20'h0_0CAF;
      wr_en = 2'b11; wr_blk = 3'b111;
      rd_addr = wa(30); rd_en = 1'b1; rd_blk = 3'b111;
      @(negedge clk);
      wr_en = 2'b00; wr_blk = 3'b000; rd_en = 1'b0; rd_blk = 3'b000;
      rd_expect("R9 collision write kept", wa(30), {16'h0CAF, 17'h0BEEF}, 2'b00);
   endtask

   task automatic t_single();
      int bits [3];
      bits[0] = 3; bits[1] = 20; bits[2] = 38;
      for (int i = 0; i < 3; i++) begin
         wr(wa(40 + i), 33'h1_5A5A_A5A5);
         inject(wa(40 + i), 40'd1 << bits[i]);
         rd_expect("R5 R10 single corrected", wa(40 + i), 33'h1_5A5A_A5A5, 2'b01);
      end
   endtask

   task automatic t_parity();
      wr(wa(50), 33'h0_7777_0001);
      inject(wa(50), 40'h80_0000_0000);
      rd_expect("R11 parity bit flip", wa(50), 33'h0_7777_0001, 2'b01);
   endtask

   task automatic t_double();
      wr(wa(51), 33'h0_0C0C_3030);
      inject(wa(51), (40'd1 << 2) | (40'd1 << 30));
      rd(wa(51));
      check("R5 double detected", 64'({err_multi, err_corr}), 64'b11);
   endtask

   task automatic t_pipe();
      @(negedge clk);
      dec_pipe = 1'b1;
      repeat (3) @(negedge clk);
      @(negedge clk);
      rd_addr = wa(12); rd_en = 1'b1; rd_blk = 3'b111;
      @(negedge clk);
      rd_en = 1'b0; rd_blk = 3'b000;
      check("R6 piped not yet valid", 64'({rd_data_hi, rd_data_lo}), 64'd0);
      @(negedge clk);
      check("R6 piped valid", 64'(out_word()), 64'(33'h0_AAAA_5555));
      wr(wa(52), 33'h1_0000_FFFF);
      inject(wa(52), 40'd1 << 11);
      rd_expect("R6 piped flags aligned", wa(52), 33'h1_0000_FFFF, 2'b01);
      rd(wa(52), 3'b011, 1'b1);
      check("R6 R7 piped gated read", 64'({rd_data_hi, rd_data_lo, err_multi, err_corr}), 64'd0);
      @(negedge clk);
      dec_pipe = 1'b0;
   endtask

   initial begin
      #(CLK_P * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      wr_addr = '0; wr_data_hi = '0; wr_data_lo = '0; wr_en = 2'b00; wr_blk = 3'b000;
      inj_en = 1'b0; inj_mask = '0; rd_rst_n = 1'b0; rd_addr = '0; rd_en = 1'b0;
      rd_blk = 3'b000; dec_pipe = 1'b0;
      repeat (3) @(negedge clk);
      t_reset();
      rd_rst_n = 1'b1;
      t_basic();
      t_addr_lsbs();
      t_partial_we();
      t_blk_write();
      t_blk_read();
      t_collide();
      t_single();
      t_parity();
      t_double();
      t_pipe();
      repeat (2) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule